// File: doc/BRIEF.md
# CAN Bus Resynchronization Detector

This block decides when a CAN node that has lost step with the bus may take part in bus traffic again. A node loses step when it comes out of standby or reaches bus-off. Once per bit time, the bit-timing logic gives the block a strobe and the sampled receive level. The block counts unbroken stretches of recessive bits. Each stretch of eleven recessive bits counts as one idle sequence. The block raises a synchronized flag once enough sequences have been seen.

The controller starts a new search by pulsing the start request. Normally 128 sequences are needed. A fast mode needs only one, but the fast mode applies only while the node is not bus-off. The count of completed sequences is also brought out, so that progress can be watched while debugging.

Top module: `can_rsync_det`

## Requirements
- R1: After reset, `synced` is 0 and `seq_count` is 0.
- R2: A recessive bit is `rx_bit`=1 and is taken on a cycle with `bit_stb`=1. The strobe that carries the 11th consecutive recessive bit increments `seq_count` by one, and the new value is visible after that clock edge.
- R3: A dominant bit (`rx_bit`=0) on a strobe discards the recessive bits gathered so far in the current run. It leaves `seq_count` unchanged.
- R4: After a run is counted, the bit count restarts from zero. An unbroken stretch of 11·n recessive bits therefore counts as n sequences, and a stretch of 11·n−1 bits counts as n−1.
- R5: With `fast_en`=0, `synced` rises on the edge at which `seq_count` reaches 128, and not before.
- R6: When `fast_en`=1 and `bus_off`=0 on the strobe that completes a sequence, `synced` rises on that edge. This also holds if earlier sequences were counted in the slow mode.
- R7: When `bus_off`=1, 128 sequences are required whatever the value of `fast_en`.
- R8: A `start_req` pulse clears `seq_count`, the partial run and `synced`. When it coincides with a strobe, it takes priority over that strobe.
- R9: Once set, `synced` stays at 1 until `start_req` or reset. While `synced` is 1, `seq_count` holds its value and strobed bits have no effect.
- R10: Clock cycles with `bit_stb`=0 leave the block's state unchanged, whatever the value of `rx_bit`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bit_stb | input | 1 | One-cycle pulse per bit time that qualifies `rx_bit` |
| rx_bit | input | 1 | Sampled bus level, 1 = recessive, 0 = dominant |
| start_req | input | 1 | Starts a new resynchronization search |
| bus_off | input | 1 | The node is in the bus-off state |
| fast_en | input | 1 | Allows the one-sequence shortcut when the node is not bus-off |
| synced | output | 1 | A valid entry point has been found |
| seq_count | output | 8 | Number of 11-bit recessive sequences counted since the last start |

## Verification
The checker assumes that `bus_off` and `fast_en` are meaningful at the strobe that closes a run, because that is the moment the goal is judged. It also takes `start_req` as a command that can arrive on any cycle, including a strobe cycle. The stimulus sends each strobe as a single-cycle pulse followed by an idle cycle. During that idle cycle `rx_bit` is driven to the opposite level, so any leak of unstrobed data shows up in the counts. Mode inputs change only between strobes or together with one, never between the edge that closes a run and its check.

// File: rtl/can_rsync_pkg.sv
package can_rsync_pkg;

  // Number of idle sequences that must be seen before rejoining the bus
  function automatic int unsigned rsync_goal(input logic fast, input logic boff,
                                             input int unsigned full);
    return (fast && !boff) ? 1 : full;
  endfunction

endpackage

// File: rtl/can_rsync_rst_sync.sv
module can_rsync_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
    end else begin
      pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = pipe_q[STAGES-1];

endmodule

// File: rtl/can_rsync_run_cnt.sv
module can_rsync_run_cnt #(
  parameter int unsigned RUN_LEN = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic stb,
  input  logic recessive,
  input  logic hold,
  output logic run_done
);

  localparam int unsigned RUN_W = (RUN_LEN > 2) ? $clog2(RUN_LEN) : 1;
  localparam logic [RUN_W-1:0] LAST = RUN_W'(RUN_LEN - 1);

  logic [RUN_W-1:0] cnt_q;
  logic [RUN_W-1:0] cnt_d;
  logic             take;
  logic             cnt_en;

  assign take     = stb && !hold && !clr;
  assign run_done = take && recessive && (cnt_q == LAST);
  assign cnt_en   = clr || take;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (take) begin
      if (!recessive || (cnt_q == LAST)) begin
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/can_rsync_seq_cnt.sv
module can_rsync_seq_cnt
  import can_rsync_pkg::*;
#(
  parameter int unsigned SEQ_NEEDED = 128,
  parameter int unsigned SEQ_W      = $clog2(SEQ_NEEDED + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run_done,
  input  logic             fast_en,
  input  logic             bus_off,
  output logic [SEQ_W-1:0] seq_cnt,
  output logic             synced
);

  logic [SEQ_W-1:0] seq_q;
  logic [SEQ_W-1:0] seq_d;
  logic [SEQ_W-1:0] seq_inc;
  logic [SEQ_W-1:0] goal;
  logic             sync_q;
  logic             sync_d;
  logic             upd_en;

  assign seq_inc = seq_q + 1'b1;
  assign goal    = SEQ_W'(rsync_goal(fast_en, bus_off, SEQ_NEEDED));
  assign upd_en  = clr || run_done;

  always_comb begin
    seq_d  = seq_q;
    sync_d = sync_q;
    if (clr) begin
      seq_d  = '0;
      sync_d = 1'b0;
    end else if (run_done) begin
      seq_d = seq_inc;
      if (seq_inc >= goal) begin
        sync_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q  <= '0;
      sync_q <= 1'b0;
    end else if (upd_en) begin
      seq_q  <= seq_d;
      sync_q <= sync_d;
    end
  end

  assign seq_cnt = seq_q;
  assign synced  = sync_q;

endmodule

// File: rtl/can_rsync_det.sv
module can_rsync_det #(
  parameter int unsigned RUN_LEN    = 11,
  parameter int unsigned SEQ_NEEDED = 128,
  parameter int unsigned SEQ_W      = $clog2(SEQ_NEEDED + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_stb,
  input  logic             rx_bit,
  input  logic             start_req,
  input  logic             bus_off,
  input  logic             fast_en,
  output logic             synced,
  output logic [SEQ_W-1:0] seq_count
);

  logic rst_n_int;
  logic run_done;
  logic sync_int;

  can_rsync_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  can_rsync_run_cnt #(.RUN_LEN(RUN_LEN)) u_run_cnt (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .clr       (start_req),
    .stb       (bit_stb),
    .recessive (rx_bit),
    .hold      (sync_int),
    .run_done  (run_done)
  );

  can_rsync_seq_cnt #(.SEQ_NEEDED(SEQ_NEEDED), .SEQ_W(SEQ_W)) u_seq_cnt (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .clr      (start_req),
    .run_done (run_done),
    .fast_en  (fast_en),
    .bus_off  (bus_off),
    .seq_cnt  (seq_count),
    .synced   (sync_int)
  );

  assign synced = sync_int;

endmodule

// File: rtl/can_rsync_chk.sv
module can_rsync_chk #(
  parameter int unsigned SEQ_NEEDED = 128,
  parameter int unsigned SEQ_W      = $clog2(SEQ_NEEDED + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_stb,
  input logic             rx_bit,
  input logic             start_req,
  input logic             bus_off,
  input logic             fast_en,
  input logic             synced,
  input logic [SEQ_W-1:0] seq_count
);

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |=> (!synced && seq_count == '0)); // R8

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !start_req |=> (seq_count == $past(seq_count) ||
                    seq_count == $past(seq_count) + 1'b1)); // R2

  AST_SEQ_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(seq_count) <= SEQ_NEEDED); // R5

  AST_SYNC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (synced && !start_req) |=> (synced && $stable(seq_count))); // R9

  AST_NO_STB_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_stb && !start_req) |=> ($stable(seq_count) && $stable(synced))); // R10

  AST_SYNC_ON_RECESSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(synced) |-> $past(bit_stb && rx_bit && !start_req)); // R2

  AST_SYNC_GOAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(synced) |-> (int'(seq_count) == SEQ_NEEDED ||
                       ($past(fast_en && !bus_off) && seq_count != '0))); // R6

  AST_BUSOFF_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(synced) && $past(bus_off)) |-> int'(seq_count) == SEQ_NEEDED); // R7

endmodule

bind can_rsync_det can_rsync_chk #(.SEQ_NEEDED(SEQ_NEEDED), .SEQ_W(SEQ_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bit_stb   (bit_stb),
  .rx_bit    (rx_bit),
  .start_req (start_req),
  .bus_off   (bus_off),
  .fast_en   (fast_en),
  .synced    (synced),
  .seq_count (seq_count)
);

// File: tb/can_rsync_det_bench.sv
module can_rsync_det_bench;

  localparam int RUN   = 11;
  localparam int FULL  = 128;

  logic       clk;
  logic       rst_n;
  logic       bit_stb;
  logic       rx_bit;
  logic       start_req;
  logic       bus_off;
  logic       fast_en;
  logic       synced;
  logic [7:0] seq_count;

  int n_chk;
  int n_fail;

  can_rsync_det u_can_rsync_det (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_stb   (bit_stb),
    .rx_bit    (rx_bit),
    .start_req (start_req),
    .bus_off   (bus_off),
    .fast_en   (fast_en),
    .synced    (synced),
    .seq_count (seq_count)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_state(input string tag, input int exp_seq, input int exp_sync);
    chk({tag, " seq_count"}, int'(seq_count), exp_seq);
    chk({tag, " synced"}, int'(synced), exp_sync);
  endtask

  // One strobed bit, then one unstrobed cycle carrying the opposite level
  task automatic send_bit(input logic b, input logic st);
    @(negedge clk);
    bit_stb   = 1'b1;
    rx_bit    = b;
    start_req = st;
    @(negedge clk);
    bit_stb   = 1'b0;
    start_req = 1'b0;
    rx_bit    = ~b;
  endtask

  task automatic send_ones(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b1, 1'b0);
  endtask

  task automatic restart();
    @(negedge clk);
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
  endtask

  initial begin
    n_chk = 0;
    n_fail = 0;
    rst_n = 1'b0;
    bit_stb = 1'b0;
    rx_bit = 1'b1;
    start_req = 1'b0;
    bus_off = 1'b0;
    fast_en = 1'b0;
    repeat (3) @(negedge clk);
    check_state("R1 in reset", 0, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_state("R1 after reset", 0, 0);

    // Sweep every mode combination through a continuous recessive stream
    for (int cfg = 0; cfg < 4; cfg++) begin
      int need;
      int total;
      fast_en = cfg[0];
      bus_off = cfg[1];
      need = (fast_en && !bus_off) ? 1 : FULL;
      total = need * RUN + RUN;
      restart();
      check_state("R8 start", 0, 0);
      for (int i = 1; i <= total; i++) begin
        int runs;
        send_bit(1'b1, 1'b0);
        runs = i / RUN;
        if (runs >= need) begin
          chk(bus_off ? "R7 sync" : (fast_en ? "R6 sync" : "R5 sync"), int'(synced), 1);
          chk("R9 frozen seq_count", int'(seq_count), need);
        end else begin
          chk("R4 seq_count", int'(seq_count), runs);
          chk(bus_off ? "R7 no sync" : "R5 no sync", int'(synced), 0);
        end
      end
      // Unstrobed cycles with dominant level change nothing
      @(negedge clk);
      rx_bit = 1'b0;
      repeat (3) @(negedge clk);
      check_state("R10 idle after sync", need, 1);
      restart();
      check_state("R9 start drops sync", 0, 0);
    end

    // Dominant bit at every position inside a run
    fast_en = 1'b0;
    bus_off = 1'b0;
    for (int k = 0; k < RUN; k++) begin
      restart();
      send_ones(k);
      send_bit(1'b0, 1'b0);
      check_state("R3 dominant breaks run", 0, 0);
      send_ones(RUN - 1);
      check_state("R2 one short", 0, 0);
      send_ones(1);
      check_state("R2 full run", 1, 0);
    end
    send_ones(5);
    send_bit(1'b0, 1'b0);
    check_state("R3 completed count kept", 1, 0);

    // Stretch boundaries
    restart();
    send_ones(2 * RUN - 1);
    check_state("R4 21 bits", 1, 0);
    send_ones(1);
    check_state("R4 22 bits", 2, 0);

    // Start clears the partial run
    restart();
    send_ones(5);
    restart();
    send_ones(6);
    check_state("R8 partial cleared", 0, 0);
    send_ones(5);
    check_state("R8 fresh run", 1, 0);

    // Start coinciding with the closing strobe wins
    restart();
    send_ones(RUN - 1);
    send_bit(1'b1, 1'b1);
    check_state("R8 priority", 0, 0);
    send_ones(RUN);
    check_state("R8 after priority", 1, 0);

    // Switch to fast mode after slow progress
    restart();
    send_ones(3 * RUN);
    check_state("R6 slow progress", 3, 0);
    fast_en = 1'b1;
    send_ones(RUN - 1);
    check_state("R6 pending", 3, 0);
    send_ones(1);
    check_state("R6 late fast", 4, 1);

    // Fast enabled but bus-off at the closing strobe
    restart();
    bus_off = 1'b1;
    send_ones(RUN);
    check_state("R7 bus-off fast", 1, 0);
    bus_off = 1'b0;
    fast_en = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule